// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block drives the serial management bus that connects a MAC to its PHY devices. Software assembles a complete 32-bit management frame (start code, opcode, PHY address, register address, turnaround and data) and writes it as one word into the frame register. The controller sends 32 preamble ones, then the frame MSB first on the data line, while generating the management clock from the system clock.

For a read opcode the controller stops driving the data line at the second turnaround bit. It samples the 16 bits returned by the PHY and replaces the low half of the frame register with them. Completion of every frame latches an event flag, which software clears by writing a one, and which can raise a level interrupt.

The management clock half-period, in system clocks, comes from a 6-bit divider field that sits one bit above the bottom of the speed register. Software picks it as ceil(system clock / 5 MHz), saturated at 63, which keeps the management clock at or below 2.5 MHz. The divider is latched when a frame starts. The whole interface is gated by a mode-enable bit in the control register.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: Each frame is 32 ones followed by the 32 bits of the frame word, most significant bit first. A read word 0x60020000 | (phy << 23) | (reg << 18) therefore appears on the line as start 01, opcode 10, then the PHY and register addresses. The line value for a bit is sampled by the PHY on the management clock rising edge and changes only at a rising edge.
- R2: For a frame whose opcode bits 29:28 are not 10, all 64 bits, including the write data in bits 15:0, are driven with output enable high.
- R3: For a read (opcode bits 29:28 = 10), output enable is high for line bits 0..46 and low for bits 47..63, which are the second turnaround bit and the 16 data bits. After completion, frame register bits 15:0 hold the 16 sampled bits, first sampled in bit 15, and bits 31:16 are unchanged.
- R4: The management clock half-period equals the divider field in system clocks, and the clock stays low while no frame runs. A frame write while the divider is 0 is ignored: no clock, register unchanged.
- R5: Only speed register bits 6:1 (the divider) are writable. All other bits of that register read 0 whatever is written.
- R6: Status bit 0 (event) sets when a frame completes. Writing 1 to it clears it, and writing 0 leaves it set.
- R7: The interrupt output equals event AND control bit 1 (interrupt enable), registered one cycle.
- R8: With control bit 0 (management mode enable) at 0, frame register writes are ignored, and no frame starts.
- R9: Status bit 1 (busy) reads 1 while a frame runs. A frame register write during that time is ignored.
- R10: After reset all registers read 0, and the management clock, output enable and interrupt are 0.
- R11: Register reads return the addressed word on reg_rdata in the cycle after reg_rd is sampled. The word addresses are 0 control, 1 status, 2 speed, 3 frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Frame completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with its default 6-bit divider and programs divider values of 0, 2 and 3. The nonzero values keep a full 64-bit frame to a few hundred system clocks, so write and read frames, the busy window and the event/interrupt sequence all fit in short directed runs. A divider of 0 exercises the blocked-start case. A bench responder records every line bit and its output enable at each clock rising edge, and returns chosen data during read frames. This makes it possible to compare the full line pattern and the release point with expected values.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int WORD_W     = 32;
  localparam int PRE_BITS   = 32;
  localparam int SHIFT_W    = PRE_BITS + WORD_W;
  localparam int BIT_CNT_W  = $clog2(SHIFT_W + 1);
  localparam int RD_W       = 16;
  // line index of frame bit 16 (second turnaround bit)
  localparam int TA_RELEASE = PRE_BITS + (WORD_W - 1 - 16);
  localparam int DATA_FIRST = TA_RELEASE + 1;
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int DIV_LSB    = 1;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_SPEED = 2'd2,
    ADDR_FRAME = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = run && (div_q != '0) && ({1'b0, cnt} + (DIV_W+1)'(1) >= {1'b0, div_q});
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      div_q <= '0;
    end else if (!run) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      div_q <= div;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_engine.sv
`timescale 1ns/1ps
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] frame_in,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              done_rd,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [RD_W-1:0]   rd_data
);
  localparam logic [BIT_CNT_W-1:0] L_TOTAL = BIT_CNT_W'(SHIFT_W);
  localparam logic [BIT_CNT_W-1:0] L_REL   = BIT_CNT_W'(TA_RELEASE);
  localparam logic [BIT_CNT_W-1:0] L_DATA  = BIT_CNT_W'(DATA_FIRST);

  logic [SHIFT_W-1:0]   sh;
  logic [BIT_CNT_W-1:0] bit_idx;
  logic [BIT_CNT_W-1:0] nxt;
  logic                 is_rd;

  assign nxt    = bit_idx + BIT_CNT_W'(1);
  assign mdio_o = sh[SHIFT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bit_idx <= '0;
      is_rd   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      done_rd <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else begin
      done    <= 1'b0;
      done_rd <= 1'b0;
      if (start && !busy) begin
        sh      <= {{PRE_BITS{1'b1}}, frame_in};
        bit_idx <= '0;
        is_rd   <= (frame_in[OP_HI:OP_LO] == OP_READ);
        busy    <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise) begin
          if (is_rd && bit_idx >= L_DATA)
            rd_data <= {rd_data[RD_W-2:0], mdio_i};
          sh      <= {sh[SHIFT_W-2:0], 1'b0};
          bit_idx <= nxt;
          mdio_oe <= (nxt < L_TOTAL) && !(is_rd && nxt >= L_REL);
        end else if (fall && bit_idx == L_TOTAL) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          done_rd <= is_rd;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_done_rd,
  input  logic [RD_W-1:0]   eng_rd_data,
  output logic              start,
  output logic [DIV_W-1:0]  div,
  output logic              evt,
  output logic              irq_en
);
  logic              mii_en;
  logic [WORD_W-1:0] frame;
  logic [WORD_W-1:0] rd_mux;

  assign start = reg_wr && (reg_addr == ADDR_W'(ADDR_FRAME)) && mii_en && !eng_busy && (div != '0);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(ADDR_CTRL):  rd_mux[1:0] = {irq_en, mii_en};
      ADDR_W'(ADDR_STAT):  rd_mux[1:0] = {eng_busy, evt};
      ADDR_W'(ADDR_SPEED): rd_mux[DIV_LSB +: DIV_W] = div;
      default:             rd_mux = frame;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mii_en    <= 1'b0;
      irq_en    <= 1'b0;
      div       <= '0;
      frame     <= '0;
      evt       <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(ADDR_CTRL)) begin
        mii_en <= reg_wdata[0];
        irq_en <= reg_wdata[1];
      end
      if (reg_wr && reg_addr == ADDR_W'(ADDR_SPEED))
        div <= reg_wdata[DIV_LSB +: DIV_W];
      if (start)
        frame <= reg_wdata;
      else if (eng_done_rd)
        frame[RD_W-1:0] <= eng_rd_data;
      if (eng_done)
        evt <= 1'b1;
      else if (reg_wr && reg_addr == ADDR_W'(ADDR_STAT) && reg_wdata[0])
        evt <= 1'b0;
      irq <= evt && irq_en;
      if (reg_rd)
        reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mdio_frame_ctrl.sv
`timescale 1ns/1ps
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             start, eng_busy, eng_done, eng_done_rd;
  logic             rise, fall, evt, irq_en;
  logic [RD_W-1:0]  eng_rd_data;
  logic [DIV_W-1:0] div;

  mdio_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_done_rd(eng_done_rd), .eng_rd_data(eng_rd_data),
    .start(start), .div(div), .evt(evt), .irq_en(irq_en)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(eng_busy), .div(div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .frame_in(reg_wdata),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(eng_busy),
    .done(eng_done), .done_rd(eng_done_rd), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_data(eng_rd_data)
  );
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_oe,
  input logic irq,
  input logic busy,
  input logic evt,
  input logic irq_en
);
  assert_mdc_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_oe_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  assert_evt_on_done_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> evt);

  assert_irq_on_R7: assert property (@(posedge clk) disable iff (rst)
    (evt && irq_en) |=> irq);

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
    !(evt && irq_en) |=> !irq);
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_oe(mdio_oe), .irq(irq),
  .busy(eng_busy), .evt(evt), .irq_en(irq_en)
);

// File: tb/mdio_frame_ctrl_test.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_SPEED = 2'd2, A_FRAME = 2'd3;

  always #2 clk = ~clk;

  mdio_frame_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic watch_frame(input logic [15:0] resp, output logic [63:0] bits,
                             output logic [63:0] oes, output int gap);
    int n = 0;
    int cyc = 0;
    int first = 0;
    logic pm, po, poe;
    bits = '0; oes = '0; gap = 0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (n < 64 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (mdc && !pm) begin
        bits[63-n] = po;
        oes[63-n]  = poe;
        if (n == 0) first = cyc;
        else if (n == 1) gap = cyc - first;
        n++;
        mdio_i = (n >= 48 && n < 64) ? resp[63-n] : 1'b1;
      end
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    mdio_i = 1'b1;
  endtask

  task automatic quiet_mdc(input string tag);
    bit seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc) seen = 1;
    end
    check(tag, {63'd0, seen}, 64'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 mdc", {63'd0, mdc}, 64'd0);
    check("R10 oe", {63'd0, mdio_oe}, 64'd0);
    check("R10 irq", {63'd0, irq}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], v);
      check("R10 reg", {32'd0, v}, 64'd0);
    end
  endtask

  task automatic t_speed;
    logic [31:0] v;
    bus_write(A_SPEED, 32'hFFFF_FFFF);
    bus_read(A_SPEED, v);
    check("R5 speed mask", {32'd0, v}, 64'h7E);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = A_CTRL;
    check("R11 before edge", {32'd0, reg_rdata}, 64'h7E);
    @(negedge clk);
    reg_rd = 1'b0;
    check("R11 after edge", {32'd0, reg_rdata}, 64'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_SPEED, 32'h4);
    bus_write(A_FRAME, 32'h6002_0000);
    quiet_mdc("R8 no clock");
    bus_read(A_FRAME, v);
    check("R8 frame unchanged", {32'd0, v}, 64'd0);
  endtask

  task automatic t_div0;
    logic [31:0] v;
    bus_write(A_CTRL, 32'h1);
    bus_write(A_SPEED, 32'h0);
    bus_write(A_FRAME, 32'h5002_1234);
    quiet_mdc("R4 div0 no clock");
    bus_read(A_FRAME, v);
    check("R4 div0 frame unchanged", {32'd0, v}, 64'd0);
  endtask

  task automatic t_write_frame;
    logic [31:0] v, w;
    logic [63:0] bits, oes;
    int gap;
    w = 32'h5002_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'hBEEF;
    bus_write(A_CTRL, 32'h1);
    bus_write(A_SPEED, 32'd2 << 1);
    bus_write(A_FRAME, w);
    fork
      watch_frame(16'h0, bits, oes, gap);
      begin
        logic [31:0] s;
        repeat (10) @(negedge clk);
        bus_read(A_STAT, s);
        check("R9 busy", {32'd0, s}, 64'h2);
        bus_write(A_FRAME, 32'h6002_0000);
      end
    join
    check("R2 write bits", bits, {32'hFFFF_FFFF, w});
    check("R2 write oe", oes, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R4 half period div2", 64'(gap), 64'd4);
    repeat (12) @(negedge clk);
    bus_read(A_STAT, v);
    check("R6 event set", {32'd0, v}, 64'h1);
    bus_read(A_FRAME, v);
    check("R9 ignored write", {32'd0, v}, {32'd0, w});
    check("R7 irq masked", {63'd0, irq}, 64'd0);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, v);
    check("R6 write0 keeps", {32'd0, v}, 64'h1);
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, v);
    check("R6 write1 clears", {32'd0, v}, 64'h0);
  endtask

  task automatic t_read_frame;
    logic [31:0] v, w;
    logic [63:0] bits, oes;
    int gap;
    w = 32'h6002_0000 | (32'h11 << 23) | (32'h1A << 18);
    bus_write(A_CTRL, 32'h3);
    bus_write(A_SPEED, 32'd3 << 1);
    bus_write(A_FRAME, w);
    watch_frame(16'hA5C3, bits, oes, gap);
    check("R1 preamble", {32'd0, bits[63:32]}, 64'hFFFF_FFFF);
    check("R1 start+op", {60'd0, bits[31:28]}, 64'h6);
    check("R1 driven bits", bits[63:17], {32'hFFFF_FFFF, w[31:17]});
    check("R3 read oe", oes, 64'hFFFF_FFFF_FFFE_0000);
    check("R4 half period div3", 64'(gap), 64'd6);
    repeat (16) @(negedge clk);
    check("R7 irq raised", {63'd0, irq}, 64'd1);
    bus_read(A_FRAME, v);
    check("R3 captured", {32'd0, v}, {32'd0, w[31:16], 16'hA5C3});
    bus_write(A_STAT, 32'h1);
    @(negedge clk);
    check("R7 irq cleared", {63'd0, irq}, 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_speed();
    t_disabled();
    t_div0();
    t_write_frame();
    t_read_frame();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule